// File: doc/BRIEF.md
# Per-Set Priority Position Mapper

This block takes the eight request lines of one interrupt set and places each of them at a global priority level. A 32-bit order register holds eight 3-bit codes, one for each priority position. The code in a position names the source that occupies that position. A mode input chooses between two fixed tables of global levels, Grouped and Spread, and each position is then driven onto the level that the chosen table gives it. The result is a 129-bit level vector with one bit per global level, which a downstream arbiter scans for the winner.

Software writes the order register through a single-cycle write port, and its contents can be read back. A new order applies from the cycle after the write. When two positions hold the same code the block raises a combinational error flag, but it still maps exactly what the fields say. Masking, arbitration and vector encoding belong to other blocks.

Top module: `pmap_position_mapper`

## Requirements
- R1: After reset the order register reads 0x05309770, so position n holds code n. The position fields sit at bits 31:29, 28:26, 25:23 and 22:20 for positions 0 to 3, and at 15:13, 12:10, 9:7 and 6:4 for positions 4 to 7.
- R2: A cycle with `wr_en` high loads `wr_data` into the order register with bits 19:16 and 3:0 forced to zero. Those bits always read as zero.
- R3: A write is visible on `order_rd` and in the level mapping right after the clock edge that captures it.
- R4: With `spread_mode` = 0 (Grouped), positions 0 to 7 drive global levels 2, 3, 4, 5, 30, 31, 32 and 33. Each of those levels is high exactly when the source named by that position's code is requesting.
- R5: With `spread_mode` = 1 (Spread), positions 0 to 7 drive global levels 1, 11, 25, 39, 53, 67, 85 and 103, under the same rule.
- R6: Every level that the active mode does not use is zero, and this includes all levels of the inactive mode.
- R7: `duplicate_code` is high exactly when at least two positions hold the same code. It follows the register contents with no extra delay.
- R8: When codes are duplicated, the mapping still follows the fields. One source can then drive several levels, and a source that no position names drives none.
- R9: In a cycle with `wr_en` low, the order register keeps its value whatever `wr_data` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 8 | Raw request from each source of the set, indexed by code |
| spread_mode | input | 1 | 0 selects the Grouped level table, 1 selects the Spread table |
| wr_en | input | 1 | Write strobe for the order register |
| wr_data | input | 32 | Value to load into the order register |
| order_rd | output | 32 | Current contents of the order register |
| level_req | output | 129 | Request bit for each global priority level |
| duplicate_code | output | 1 | Two or more positions hold the same code |

## Verification
The only state is the order register. A wrong field shows up at once on `order_rd`, and as soon as any source requests, its request lands on a wrong level or on no level at all. The bench drives one source at a time, so each position's mapping is checked on its own, in both modes and for both the reset order and a rewritten order. A write captured late or early is caught by sampling the level vector in the first cycle after the capturing edge. A stuck or inverted duplicate detector is caught by comparing a unique code set against one in which a code is repeated.

// File: rtl/pmap_pkg.sv
package pmap_pkg;

    localparam int SRC_COUNT = 8;
    localparam int CODE_W    = $clog2(SRC_COUNT);
    localparam int ORDER_W   = 32;

    // Implemented bits of the order register and its reset contents.
    localparam logic [ORDER_W-1:0] ORDER_MASK  = 32'hFFF0_FFF0;
    localparam logic [ORDER_W-1:0] ORDER_RESET = 32'h0530_9770;

    typedef logic [CODE_W-1:0]          code_t;
    typedef code_t [SRC_COUNT-1:0]      code_vec_t;

    typedef struct packed {
        logic [ORDER_W-1:0] order;
    } order_state_t;

    // Low bit of the code field for a position: the first four positions
    // occupy the upper half word, the last four the lower half word.
    function automatic int field_lsb(input int pos);
        if (pos < SRC_COUNT / 2) begin
            return 29 - CODE_W * pos;
        end
        return 13 - CODE_W * (pos - SRC_COUNT / 2);
    endfunction

endpackage

// File: rtl/pmap_order_reg.sv
module pmap_order_reg
    import pmap_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ORDER_W-1:0] wr_data,
    output logic [ORDER_W-1:0] order_o,
    output code_vec_t          codes_o
);

    order_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.order = wr_data & ORDER_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{order: ORDER_RESET};
        end else begin
            st_q <= st_d;
        end
    end

    assign order_o = st_q.order;

    for (genvar p = 0; p < SRC_COUNT; p++) begin : g_field
        localparam int LSB = field_lsb(p);
        assign codes_o[p] = st_q.order[LSB +: CODE_W];
    end

    // R1: first cycle out of reset shows the reset order
    p_reset_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (order_o == ORDER_RESET));

    // R2: captured write equals the masked data word
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en)) |-> (order_o == ($past(wr_data) & ORDER_MASK)));

    // R2: unimplemented bits never read as one
    p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (order_o & ~ORDER_MASK) == '0);

    // R9: no write, no change
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en)) |-> $stable(order_o));

endmodule

// File: rtl/pmap_permute.sv
module pmap_permute
    import pmap_pkg::*;
(
    input  code_vec_t            codes_i,
    input  logic [SRC_COUNT-1:0] src_req_i,
    output logic [SRC_COUNT-1:0] pos_req_o,
    output logic                 dup_o
);

    logic [SRC_COUNT-1:0] used_codes;

    always_comb begin
        for (int p = 0; p < SRC_COUNT; p++) begin
            pos_req_o[p] = src_req_i[codes_i[p]];
        end
    end

    // Pairwise comparison of every two positions.
    always_comb begin
        dup_o = 1'b0;
        for (int i = 0; i < SRC_COUNT; i++) begin
            for (int j = i + 1; j < SRC_COUNT; j++) begin
                if (codes_i[i] == codes_i[j]) begin
                    dup_o = 1'b1;
                end
            end
        end
    end

    // Coverage of the code space: with eight slots and eight codes,
    // all codes are used exactly when none repeats.
    always_comb begin
        used_codes = '0;
        for (int p = 0; p < SRC_COUNT; p++) begin
            used_codes[codes_i[p]] = 1'b1;
        end
    end

    always_comb begin
        p_dup_flag_r7: assert (dup_o != (&used_codes));
    end

endmodule

// File: rtl/pmap_level_place.sv
module pmap_level_place
    import pmap_pkg::*;
#(
    parameter int                         NUM_LEVELS  = 129,
    parameter int                         LEVEL_W     = 8,
    parameter logic [SRC_COUNT*LEVEL_W-1:0] GROUPED_TAB = '0,
    parameter logic [SRC_COUNT*LEVEL_W-1:0] SPREAD_TAB  = '0
) (
    input  logic [SRC_COUNT-1:0]  pos_req_i,
    input  logic                  spread_i,
    output logic [NUM_LEVELS-1:0] level_o
);

    localparam int MODES = 2;
    localparam logic [MODES*SRC_COUNT*LEVEL_W-1:0] TABS = {SPREAD_TAB, GROUPED_TAB};

    logic [MODES-1:0][NUM_LEVELS-1:0] mode_levels;

    for (genvar m = 0; m < MODES; m++) begin : g_mode
        localparam int BASE = m * SRC_COUNT * LEVEL_W;
        logic mode_on;
        assign mode_on = (spread_i == m[0]);

        always_comb begin
            mode_levels[m] = '0;
            for (int p = 0; p < SRC_COUNT; p++) begin
                if (mode_on && pos_req_i[p]) begin
                    mode_levels[m][TABS[BASE + p*LEVEL_W +: LEVEL_W]] = 1'b1;
                end
            end
        end
    end

    assign level_o = mode_levels[0] | mode_levels[1];

endmodule

// File: rtl/pmap_position_mapper.sv
module pmap_position_mapper
    import pmap_pkg::*;
#(
    parameter int NUM_LEVELS = 129,
    parameter int LEVEL_W    = $clog2(NUM_LEVELS),
    parameter logic [SRC_COUNT*LEVEL_W-1:0] GROUPED_TAB =
        {8'd33, 8'd32, 8'd31, 8'd30, 8'd5, 8'd4, 8'd3, 8'd2},
    parameter logic [SRC_COUNT*LEVEL_W-1:0] SPREAD_TAB =
        {8'd103, 8'd85, 8'd67, 8'd53, 8'd39, 8'd25, 8'd11, 8'd1}
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SRC_COUNT-1:0]  src_req,
    input  logic                  spread_mode,
    input  logic                  wr_en,
    input  logic [ORDER_W-1:0]    wr_data,
    output logic [ORDER_W-1:0]    order_rd,
    output logic [NUM_LEVELS-1:0] level_req,
    output logic                  duplicate_code
);

    code_vec_t            codes;
    logic [SRC_COUNT-1:0] pos_req;

    pmap_order_reg u_order (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .order_o (order_rd),
        .codes_o (codes)
    );

    pmap_permute u_perm (
        .codes_i   (codes),
        .src_req_i (src_req),
        .pos_req_o (pos_req),
        .dup_o     (duplicate_code)
    );

    pmap_level_place #(
        .NUM_LEVELS  (NUM_LEVELS),
        .LEVEL_W     (LEVEL_W),
        .GROUPED_TAB (GROUPED_TAB),
        .SPREAD_TAB  (SPREAD_TAB)
    ) u_place (
        .pos_req_i (pos_req),
        .spread_i  (spread_mode),
        .level_o   (level_req)
    );

    // R4: with a unique code set every request shows up on exactly one level
    p_count_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !duplicate_code |-> ($countones(level_req) == $countones(src_req)));

    // R8: a repeated code can only widen the set of driven levels up to the slot count
    p_dup_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(level_req) <= SRC_COUNT);

endmodule

// File: tb/tb_pmap_position_mapper.sv
module tb_pmap_position_mapper;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   src_req = '0;
    logic         spread_mode = 1'b0;
    logic         wr_en = 1'b0;
    logic [31:0]  wr_data = '0;
    logic [31:0]  order_rd;
    logic [128:0] level_req;
    logic         duplicate_code;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int g_tab [8] = '{2, 3, 4, 5, 30, 31, 32, 33};
    int s_tab [8] = '{1, 11, 25, 39, 53, 67, 85, 103};
    int f_lsb [8] = '{29, 26, 23, 20, 13, 10, 7, 4};

    logic [31:0] model_order;

    always #2.5 clk = ~clk;

    pmap_position_mapper dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .src_req        (src_req),
        .spread_mode    (spread_mode),
        .wr_en          (wr_en),
        .wr_data        (wr_data),
        .order_rd       (order_rd),
        .level_req      (level_req),
        .duplicate_code (duplicate_code)
    );

    function automatic logic [128:0] exp_levels(input logic [31:0] ord,
                                                input logic [7:0] req,
                                                input logic spread);
        logic [128:0] v = '0;
        for (int p = 0; p < 8; p++) begin
            int code = int'((ord >> f_lsb[p]) & 32'h7);
            if (req[code]) v[spread ? s_tab[p] : g_tab[p]] = 1'b1;
        end
        return v;
    endfunction

    function automatic bit exp_dup(input logic [31:0] ord);
        for (int i = 0; i < 8; i++)
            for (int j = i + 1; j < 8; j++)
                if (((ord >> f_lsb[i]) & 32'h7) == ((ord >> f_lsb[j]) & 32'h7)) return 1;
        return 0;
    endfunction

    task automatic chk_vec(input string tag, input logic [128:0] act, input logic [128:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive at the falling edge, sample 1 ns later.
    task automatic apply(input logic [7:0] req, input logic spread);
        @(negedge clk);
        src_req = req;
        spread_mode = spread;
        #1;
    endtask

    task automatic write_order(input logic [31:0] val);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = val;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = ~val;
        model_order = val & 32'hFFF0_FFF0;
        #1;
    endtask

    task automatic test_reset();
        apply(8'h00, 1'b0);
        chk32("R1 reset order", order_rd, 32'h0530_9770);
        chk_vec("R6 reset levels idle", level_req, '0);
        chk32("R7 reset no duplicate", {31'd0, duplicate_code}, 32'd0);
    endtask

    task automatic walk_sources(input string tag, input logic spread);
        for (int s = 0; s < 8; s++) begin
            apply(8'h01 << s, spread);
            chk_vec(tag, level_req, exp_levels(model_order, 8'h01 << s, spread));
        end
        apply(8'hFF, spread);
        chk_vec(tag, level_req, exp_levels(model_order, 8'hFF, spread));
        apply(8'hA5, spread);
        chk_vec(tag, level_req, exp_levels(model_order, 8'hA5, spread));
    endtask

    task automatic test_grouped();
        walk_sources("R4 grouped default", 1'b0);
    endtask

    task automatic test_spread();
        walk_sources("R5 spread default", 1'b1);
        apply(8'h10, 1'b1);
        chk_vec("R6 spread leaves grouped level 30 clear", level_req & (129'd1 << 30), '0);
        apply(8'h10, 1'b0);
        chk_vec("R6 grouped leaves spread level 53 clear", level_req & (129'd1 << 53), '0);
    endtask

    task automatic test_rewrite();
        write_order(32'hFAC0_688F | 32'h000F_000F);
        chk32("R2 masked write readback", order_rd, 32'hFAC0_6880);
        chk32("R7 reversed codes unique", {31'd0, duplicate_code}, 32'd0);
        // Source 0 now sits in position 7: grouped level 33, right after the edge.
        src_req = 8'h01;
        #0.5;
        chk_vec("R3 new map next cycle", level_req, 129'd1 << 33);
        walk_sources("R4 grouped reversed", 1'b0);
        walk_sources("R5 spread reversed", 1'b1);
    endtask

    task automatic test_duplicate();
        write_order(32'h2530_9770);
        chk32("R7 duplicate flag", {31'd0, duplicate_code}, {31'd0, exp_dup(model_order)});
        apply(8'h02, 1'b0);
        chk_vec("R8 source 1 at two levels", level_req, (129'd1 << 2) | (129'd1 << 3));
        apply(8'h01, 1'b0);
        chk_vec("R8 unnamed source drives nothing", level_req, '0);
        apply(8'h02, 1'b1);
        chk_vec("R8 spread duplicate", level_req, (129'd1 << 1) | (129'd1 << 11));
        write_order(32'h0530_9770);
        chk32("R7 duplicate cleared", {31'd0, duplicate_code}, 32'd0);
    endtask

    task automatic test_hold();
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            wr_en = 1'b0;
            wr_data = 32'h1234_5678 * (k + 3);
        end
        apply(8'h80, 1'b0);
        chk32("R9 order holds", order_rd, model_order);
        chk_vec("R9 mapping holds", level_req, exp_levels(model_order, 8'h80, 1'b0));
    endtask

    initial begin
        model_order = 32'h0530_9770;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_grouped();
        test_spread();
        test_rewrite();
        test_duplicate();
        test_hold();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule